// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block sits on the management side of an Ethernet PHY controller. Software or a bring-up state machine hands it one high-level request. The sequencer expands that request into the ordered list of direct register transactions that reach a register hidden behind an indirect window. It then sends those transactions, one at a time, to an MDIO master over a simple valid/acknowledge register port. The serial bit timing of MDIO and the PHY itself are handled elsewhere.

Two windows are supported. The first is the MMD window. A control register at direct address 0x0D selects a device number and a function, and a data register at 0x0E carries either an offset or a data word. The second is the debug window. A pointer register at 0x1D holds the offset, and a data register at 0x1E gives access to the selected location. Each request is a read, a write or a read-modify-write. A read-modify-write reads the target, computes (read AND mask) OR set-value, and writes the result back through the same data register. This lets one command rewrite a single field, such as a clock-select field or an enable bit, without disturbing the other bits.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: After reset `busy`, `done` and `mdio_valid` are low and `req_ready` is high.
- R2: An MMD request (`req_kind`=0) opens with three writes in this order: 0x0D with the device number, then 0x0E with the register offset, then 0x0D with 0x4000 ORed with the device number. Bits 15:14 of 0x0D are the function field, and 01 means data without increment.
- R3: An MMD read (`req_op`=00, or the reserved code 11) ends with one read of 0x0E. `rdata` returns that value and the target stays unchanged.
- R4: An MMD write (`req_op`=01) ends with one write of `req_wdata` to 0x0E, for four transactions in total.
- R5: A debug request (`req_kind`=1) writes the offset to 0x1D and then reads 0x1E, or for a write stores `req_wdata` into 0x1E.
- R6: A read-modify-write (`req_op`=10) performs the read step. It then writes (read AND `req_mask`) OR `req_wdata` to the same data register. `rdata` returns the unmodified read value.
- R7: Once `mdio_valid` is raised, address, direction and write value stay constant until `mdio_ack`, and the next step is not issued before the acknowledge.
- R8: A request is taken when `req_valid` and `req_ready` are both high. `busy` is high from the next cycle until the `done` cycle. While busy, `req_ready` is low and requests are ignored.
- R9: `done` is a one-cycle pulse in the cycle after the acknowledge of the final step, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 1 | 0 = MMD window, 1 = debug window |
| req_op | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 treated as read |
| req_dev | input | 5 | MMD device number |
| req_offset | input | 16 | Indirect register offset |
| req_wdata | input | 16 | Write value, or the OR value for read-modify-write |
| req_mask | input | 16 | AND mask for read-modify-write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Value read by the read step |
| mdio_valid | output | 1 | Direct transaction requested |
| mdio_we | output | 1 | 1 = write, 0 = read |
| mdio_addr | output | 5 | Direct register address |
| mdio_wdata | output | 16 | Direct write value |
| mdio_ack | input | 1 | Direct transaction completed |
| mdio_rdata | input | 16 | Direct read value, valid with the acknowledge |

## Verification
The hardest situation to reach is a direct transaction held pending across several cycles while the request port is being driven again. This is where a step could slip, repeat or let a second request in. The bench's responder adds a random acknowledge delay to every step. On some requests it also presents a competing request in mid-flight. It then compares the full recorded transaction list against the list expected for that request, and confirms that nothing further is issued after `done`.

// File: rtl/mis_pkg.sv
package mis_pkg;

   typedef enum logic {
      KIND_MMD = 1'b0,
      KIND_DBG = 1'b1
   } kind_e;

   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_WR  = 2'd1,
      OP_RMW = 2'd2,
      OP_RSV = 2'd3
   } op_e;

   // Step order of one indirect access
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_SEL  = 3'd1,   // control register: device, address function
      PH_OFS  = 3'd2,   // offset into data / pointer register
      PH_MODE = 3'd3,   // control register: device, data function
      PH_XFER = 3'd4,   // data register read or write
      PH_WB   = 3'd5    // write back of merged value
   } phase_e;

endpackage

// File: rtl/mis_bit_merge.sv
module mis_bit_merge #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] rd_val,
   input  logic [DW-1:0] and_mask,
   input  logic [DW-1:0] or_val,
   output logic [DW-1:0] merged
);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign merged[b] = (rd_val[b] & and_mask[b]) | or_val[b];
   end

endmodule

// File: rtl/mis_step_plan.sv
module mis_step_plan
   import mis_pkg::*;
#(
   parameter int             AW         = 5,
   parameter int             DW         = 16,
   parameter int             DEVW       = 5,
   parameter int             OFSW       = 16,
   parameter int             FUNC_LSB   = 14,
   parameter logic [1:0]     FUNC_NOINC = 2'b01,
   parameter logic [AW-1:0]  MMD_CTRL   = 5'h0D,
   parameter logic [AW-1:0]  MMD_DATA   = 5'h0E,
   parameter logic [AW-1:0]  DBG_PTR    = 5'h1D,
   parameter logic [AW-1:0]  DBG_DATA   = 5'h1E
) (
   input  phase_e            phase,
   input  kind_e             kind,
   input  op_e               op,
   input  logic [DEVW-1:0]   dev,
   input  logic [OFSW-1:0]   ofs,
   input  logic [DW-1:0]     wval,
   input  logic [DW-1:0]     merged,
   output logic [AW-1:0]     st_addr,
   output logic              st_we,
   output logic [DW-1:0]     st_wdata,
   output phase_e            nxt_phase,
   output logic              last_step
);

   localparam logic [DW-1:0] MODE_WORD = DW'(FUNC_NOINC) << FUNC_LSB;

   logic [DW-1:0] dev_word;
   logic [DW-1:0] ofs_word;
   logic          is_mmd;

   assign dev_word = DW'(dev);
   assign ofs_word = DW'(ofs);
   assign is_mmd   = (kind == KIND_MMD);

   always_comb begin
      st_addr   = '0;
      st_we     = 1'b0;
      st_wdata  = '0;
      nxt_phase = PH_IDLE;
      last_step = 1'b0;
      unique case (phase)
         PH_SEL: begin
            st_addr   = MMD_CTRL;
            st_we     = 1'b1;
            st_wdata  = dev_word;
            nxt_phase = PH_OFS;
         end
         PH_OFS: begin
            st_addr   = is_mmd ? MMD_DATA : DBG_PTR;
            st_we     = 1'b1;
            st_wdata  = ofs_word;
            nxt_phase = is_mmd ? PH_MODE : PH_XFER;
         end
         PH_MODE: begin
            st_addr   = MMD_CTRL;
            st_we     = 1'b1;
            st_wdata  = MODE_WORD | dev_word;
            nxt_phase = PH_XFER;
         end
         PH_XFER: begin
            st_addr   = is_mmd ? MMD_DATA : DBG_DATA;
            st_we     = (op == OP_WR);
            st_wdata  = (op == OP_WR) ? wval : '0;
            nxt_phase = (op == OP_RMW) ? PH_WB : PH_IDLE;
            last_step = (op != OP_RMW);
         end
         PH_WB: begin
            st_addr   = is_mmd ? MMD_DATA : DBG_DATA;
            st_we     = 1'b1;
            st_wdata  = merged;
            nxt_phase = PH_IDLE;
            last_step = 1'b1;
         end
         default: begin
            nxt_phase = PH_IDLE;
         end
      endcase
   end

endmodule

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq
   import mis_pkg::*;
#(
   parameter int             AW         = 5,
   parameter int             DW         = 16,
   parameter int             DEVW       = 5,
   parameter int             OFSW       = 16,
   parameter int             FUNC_LSB   = 14,
   parameter logic [1:0]     FUNC_NOINC = 2'b01,
   parameter bit             RMW_EN     = 1'b1,
   parameter logic [AW-1:0]  MMD_CTRL   = 5'h0D,
   parameter logic [AW-1:0]  MMD_DATA   = 5'h0E,
   parameter logic [AW-1:0]  DBG_PTR    = 5'h1D,
   parameter logic [AW-1:0]  DBG_DATA   = 5'h1E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_kind,
   input  logic [1:0]        req_op,
   input  logic [DEVW-1:0]   req_dev,
   input  logic [OFSW-1:0]   req_offset,
   input  logic [DW-1:0]     req_wdata,
   input  logic [DW-1:0]     req_mask,
   output logic              busy,
   output logic              done,
   output logic [DW-1:0]     rdata,
   output logic              mdio_valid,
   output logic              mdio_we,
   output logic [AW-1:0]     mdio_addr,
   output logic [DW-1:0]     mdio_wdata,
   input  logic              mdio_ack,
   input  logic [DW-1:0]     mdio_rdata
);

   // elaboration checks
   if (DW < FUNC_LSB + 2) begin : g_bad_func
      $error("function field does not fit in the data width");
   end
   if (DEVW > FUNC_LSB) begin : g_bad_dev
      $error("device field overlaps the function field");
   end
   if (OFSW > DW) begin : g_bad_ofs
      $error("offset wider than the data register");
   end

   phase_e          ph_q;
   phase_e          ph_nxt;
   kind_e           kind_q;
   op_e             op_q;
   logic [DEVW-1:0] dev_q;
   logic [OFSW-1:0] ofs_q;
   logic [DW-1:0]   wval_q;
   logic [DW-1:0]   mask_q;
   logic [DW-1:0]   rd_q;
   logic [DW-1:0]   merged;
   logic            done_q;
   logic            last_step;
   logic            accept;
   logic            step_ack;
   op_e             op_in;

   assign accept   = req_valid && (ph_q == PH_IDLE);
   assign step_ack = mdio_valid && mdio_ack;

   // normalise the requested operation
   always_comb begin
      op_in = op_e'(req_op);
      if (op_in == OP_RSV) op_in = OP_RD;
      if (!RMW_EN && op_in == OP_RMW) op_in = OP_RD;
   end

   if (RMW_EN) begin : g_merge
      mis_bit_merge #(.DW(DW)) u_merge (
         .rd_val   (rd_q),
         .and_mask (mask_q),
         .or_val   (wval_q),
         .merged   (merged)
      );
   end else begin : g_no_merge
      assign merged = rd_q;
   end

   mis_step_plan #(
      .AW(AW), .DW(DW), .DEVW(DEVW), .OFSW(OFSW),
      .FUNC_LSB(FUNC_LSB), .FUNC_NOINC(FUNC_NOINC),
      .MMD_CTRL(MMD_CTRL), .MMD_DATA(MMD_DATA),
      .DBG_PTR(DBG_PTR), .DBG_DATA(DBG_DATA)
   ) u_plan (
      .phase     (ph_q),
      .kind      (kind_q),
      .op        (op_q),
      .dev       (dev_q),
      .ofs       (ofs_q),
      .wval      (wval_q),
      .merged    (merged),
      .st_addr   (mdio_addr),
      .st_we     (mdio_we),
      .st_wdata  (mdio_wdata),
      .nxt_phase (ph_nxt),
      .last_step (last_step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         kind_q <= KIND_MMD;
         op_q   <= OP_RD;
         dev_q  <= '0;
         ofs_q  <= '0;
         wval_q <= '0;
         mask_q <= '1;
         rd_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            kind_q <= kind_e'(req_kind);
            op_q   <= op_in;
            dev_q  <= req_dev;
            ofs_q  <= req_offset;
            wval_q <= req_wdata;
            mask_q <= req_mask;
            ph_q   <= (kind_e'(req_kind) == KIND_MMD) ? PH_SEL : PH_OFS;
         end else if (step_ack) begin
            ph_q <= ph_nxt;
            if (ph_q == PH_XFER && op_q != OP_WR) rd_q <= mdio_rdata;
            if (last_step) done_q <= 1'b1;
         end
      end
   end

   assign req_ready  = (ph_q == PH_IDLE);
   assign busy       = (ph_q != PH_IDLE);
   assign mdio_valid = (ph_q != PH_IDLE);
   assign done       = done_q;
   assign rdata      = rd_q;

endmodule

// File: rtl/mis_chk.sv
module mis_chk #(
   parameter int            AW       = 5,
   parameter int            DW       = 16,
   parameter int            OFSW     = 16,
   parameter logic [AW-1:0] MMD_CTRL = 5'h0D,
   parameter logic [AW-1:0] DBG_PTR  = 5'h1D
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            req_kind,
   input logic [OFSW-1:0] req_offset,
   input logic            busy,
   input logic            done,
   input logic            mdio_valid,
   input logic            mdio_we,
   input logic [AW-1:0]   mdio_addr,
   input logic [DW-1:0]   mdio_wdata,
   input logic            mdio_ack
);

   // R7
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_valid && !mdio_ack |=> mdio_valid && $stable(mdio_addr)
                                  && $stable(mdio_we) && $stable(mdio_wdata));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mdio_valid && mdio_ack) && !busy);

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy);

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R2
   mmd_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_kind |=> mdio_we && mdio_addr == MMD_CTRL);

   // R5
   dbg_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_kind |=>
         mdio_we && mdio_addr == DBG_PTR && mdio_wdata == DW'($past(req_offset)));

endmodule

bind mgmt_indirect_seq mis_chk #(
   .AW(AW), .DW(DW), .OFSW(OFSW), .MMD_CTRL(MMD_CTRL), .DBG_PTR(DBG_PTR)
) u_mis_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_kind   (req_kind),
   .req_offset (req_offset),
   .busy       (busy),
   .done       (done),
   .mdio_valid (mdio_valid),
   .mdio_we    (mdio_we),
   .mdio_addr  (mdio_addr),
   .mdio_wdata (mdio_wdata),
   .mdio_ack   (mdio_ack)
);

// File: tb/mgmt_indirect_seq_bench.sv
`timescale 1ns/1ps
module mgmt_indirect_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_kind;
   logic [1:0]  req_op;
   logic [4:0]  req_dev;
   logic [15:0] req_offset, req_wdata, req_mask;
   logic        busy, done;
   logic [15:0] rdata;
   logic        mdio_valid, mdio_we, mdio_ack;
   logic [4:0]  mdio_addr;
   logic [15:0] mdio_wdata, mdio_rdata;

   always #2.5 clk = ~clk;

   mgmt_indirect_seq u_mgmt_indirect_seq (.*);

   int n_vec = 0;
   int n_bad = 0;

   // bench-side PHY register model
   logic [15:0] mii_ctrl = 16'h0;
   logic [15:0] mmd_ptr [32];
   logic [15:0] mmd_mem [int];
   logic [15:0] dbg_ptr = 16'h0;
   logic [15:0] dbg_mem [int];

   // trace of direct transactions
   logic [4:0]  tr_addr [8];
   logic        tr_we   [8];
   logic [15:0] tr_wd   [8];
   int          tr_n = 0;

   function automatic logic [15:0] seed_val(int key);
      return 16'((key * 40503) ^ 23130);
   endfunction

   function automatic logic [15:0] mmd_get(logic [4:0] d, logic [15:0] a);
      int key = int'(d) * 65536 + int'(a);
      return mmd_mem.exists(key) ? mmd_mem[key] : seed_val(key);
   endfunction

   function automatic logic [15:0] dbg_get(logic [15:0] a);
      int key = int'(a);
      return dbg_mem.exists(key) ? dbg_mem[key] : seed_val(key + 32'h0020_0000);
   endfunction

   task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp, string what);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // responder: random acknowledge latency, applies transactions to the model
   initial begin
      int wait_cnt = 0;
      mdio_ack = 1'b0;
      mdio_rdata = 16'h0;
      for (int i = 0; i < 32; i++) mmd_ptr[i] = 16'h0;
      forever begin
         @(negedge clk);
         if (mdio_ack) begin
            mdio_ack = 1'b0;
         end else if (mdio_valid) begin
            if (wait_cnt == 0) begin
               if (tr_n < 8) begin
                  tr_addr[tr_n] = mdio_addr;
                  tr_we[tr_n]   = mdio_we;
                  tr_wd[tr_n]   = mdio_wdata;
               end
               tr_n++;
               if (mdio_we) begin
                  case (mdio_addr)
                     5'h0D: mii_ctrl = mdio_wdata;
                     5'h0E: if (mii_ctrl[15:14] == 2'b00) mmd_ptr[mii_ctrl[4:0]] = mdio_wdata;
                            else mmd_mem[int'(mii_ctrl[4:0]) * 65536 + int'(mmd_ptr[mii_ctrl[4:0]])] = mdio_wdata;
                     5'h1D: dbg_ptr = mdio_wdata;
                     5'h1E: dbg_mem[int'(dbg_ptr)] = mdio_wdata;
                     default: ;
                  endcase
               end else begin
                  case (mdio_addr)
                     5'h0E: mdio_rdata = (mii_ctrl[15:14] == 2'b00) ? mmd_ptr[mii_ctrl[4:0]]
                                       : mmd_get(mii_ctrl[4:0], mmd_ptr[mii_ctrl[4:0]]);
                     5'h1E: mdio_rdata = dbg_get(dbg_ptr);
                     default: mdio_rdata = 16'h0;
                  endcase
               end
               mdio_ack = 1'b1;
               wait_cnt = int'($urandom % 4);
            end else begin
               wait_cnt--;
            end
         end
      end
   end

   task automatic run_req(bit kind, logic [1:0] op, logic [4:0] dev, logic [15:0] ofs,
                          logic [15:0] wv, logic [15:0] mask, bit poke);
      logic [4:0]  e_addr [8];
      logic        e_we   [8];
      logic [15:0] e_wd   [8];
      int          e_n = 0;
      logic [15:0] old, merged, fin;
      logic [1:0]  eop;
      logic [4:0]  dat;
      int          cyc = 0;
      eop    = (op == 2'd3) ? 2'd0 : op;
      old    = kind ? dbg_get(ofs) : mmd_get(dev, ofs);
      merged = (old & mask) | wv;
      dat    = kind ? 5'h1E : 5'h0E;
      if (!kind) begin
         e_addr[0] = 5'h0D; e_we[0] = 1'b1; e_wd[0] = {11'h0, dev};
         e_addr[1] = 5'h0E; e_we[1] = 1'b1; e_wd[1] = ofs;
         e_addr[2] = 5'h0D; e_we[2] = 1'b1; e_wd[2] = 16'h4000 | {11'h0, dev};
         e_n = 3;
      end else begin
         e_addr[0] = 5'h1D; e_we[0] = 1'b1; e_wd[0] = ofs;
         e_n = 1;
      end
      e_addr[e_n] = dat; e_we[e_n] = (eop == 2'd1); e_wd[e_n] = wv; e_n++;
      if (eop == 2'd2) begin
         e_addr[e_n] = dat; e_we[e_n] = 1'b1; e_wd[e_n] = merged; e_n++;
      end

      tr_n = 0;
      req_kind = kind; req_op = op; req_dev = dev; req_offset = ofs;
      req_wdata = wv; req_mask = mask; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R8", {31'h0, busy}, 32'h1, "busy after accept");
      while (done !== 1'b1 && cyc < 400) begin
         if (poke && cyc == 1) begin
            req_kind = ~kind; req_op = 2'd1; req_dev = dev + 5'd1;
            req_offset = ~ofs; req_wdata = 16'hDEAD; req_valid = 1'b1;
            chk(req_ready === 1'b0, "R8", {31'h0, req_ready}, 32'h0, "ready while busy");
         end
         @(negedge clk);
         req_valid = 1'b0;
         cyc++;
      end
      chk(done === 1'b1, "R9", {31'h0, done}, 32'h1, "completion reached");
      chk(tr_n == e_n, "R7", tr_n, e_n, "transaction count");
      for (int i = 0; i < e_n && i < tr_n && i < 8; i++) begin
         chk(tr_addr[i] == e_addr[i] && tr_we[i] == e_we[i],
             kind ? "R5" : "R2", {tr_we[i], 11'h0, tr_addr[i]}, {e_we[i], 11'h0, e_addr[i]},
             $sformatf("step %0d address/direction", i));
         if (e_we[i])
            chk(tr_wd[i] == e_wd[i], (eop == 2'd2 && i == e_n - 1) ? "R6" : (kind ? "R5" : "R4"),
                tr_wd[i], e_wd[i], $sformatf("step %0d write value", i));
      end
      fin = kind ? dbg_get(ofs) : mmd_get(dev, ofs);
      case (eop)
         2'd0: begin
            chk(rdata == old, kind ? "R5" : "R3", rdata, old, "read data");
            chk(fin == old, "R3", fin, old, "target unchanged by read");
         end
         2'd1: chk(fin == wv, kind ? "R5" : "R4", fin, wv, "target after write");
         default: begin
            chk(rdata == old, "R6", rdata, old, "rmw returns original");
            chk(fin == merged, "R6", fin, merged, "target after rmw");
         end
      endcase
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R9", {done, busy}, 2'b00, "done pulse ends");
      if (poke) begin
         repeat (3) @(negedge clk);
         chk(mdio_valid === 1'b0 && busy === 1'b0, "R8", {mdio_valid, busy}, 2'b00,
             "refused request not started");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0; req_op = 2'd0;
      req_dev = 5'd0; req_offset = 16'h0; req_wdata = 16'h0; req_mask = 16'hFFFF;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && mdio_valid === 1'b0 && req_ready === 1'b1,
          "R1", {busy, done, mdio_valid, req_ready}, 4'b0001, "reset state");
      rst_n = 1'b1;
      @(negedge clk);

      // clock-select field rewrite on device 7
      run_req(1'b0, 2'd2, 5'd7, 16'h8016, 16'h0018, 16'hFFE3, 1'b0);
      v = mmd_get(5'd7, 16'h8016);
      chk(v[4:2] == 3'b110, "R6", v[4:2], 3'b110, "field 4:2 rewritten");
      // clear bit 8 on device 3
      run_req(1'b0, 2'd2, 5'd3, 16'h805D, 16'h0000, 16'hFEFF, 1'b1);
      v = mmd_get(5'd3, 16'h805D);
      chk(v[8] == 1'b0, "R6", v[8], 1'b0, "bit 8 cleared");
      // set bit 8 in debug location 5
      run_req(1'b1, 2'd2, 5'd0, 16'h0005, 16'h0100, 16'hFFFF, 1'b0);
      v = dbg_get(16'h0005);
      chk(v[8] == 1'b1, "R6", v[8], 1'b1, "debug bit 8 set");
      // write then read back; reserved op code behaves as read
      run_req(1'b0, 2'd1, 5'd1, 16'h0000, 16'h8000, 16'h0000, 1'b0);
      run_req(1'b0, 2'd3, 5'd1, 16'h0000, 16'h0000, 16'h0000, 1'b1);
      run_req(1'b1, 2'd1, 5'd0, 16'h001F, 16'h0008, 16'h0000, 1'b0);
      run_req(1'b1, 2'd0, 5'd0, 16'h001F, 16'h0000, 16'h0000, 1'b0);

      for (int n = 0; n < 40; n++) begin
         run_req(1'($urandom % 2), 2'($urandom % 3), 5'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom), (n % 5) == 2);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule